// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point value held in a wide, unpacked form and writes it out as a 32-bit IEEE single-precision word. The unpacked form has a class code, a sign, a signed unbiased exponent, a 32-bit mantissa with the leading one at bit 31, and a sticky bit for precision already lost upstream. The block adds the exponent bias of 127 and aligns the mantissa to 23 fraction bits plus guard and round bits. Every mantissa bit below those is folded into sticky. The value is then rounded in one of four modes, and the block builds the result for the normal, subnormal, overflow, zero, infinity and NaN cases.

Arithmetic units in a floating-point datapath use it as their last stage. Results are computed in one combinational pass and held in an output register. `valid_o` follows `valid_i` by one clock. Three flags come with each word: overflow, underflow and inexact. Trap enables only affect when underflow is raised. Trapping itself is handled outside the block.

Top module: `sp_packer`

## Requirements
- R1: Class 0 (zero) produces a word that holds only the sign bit at bit 31, with no flags set.
- R2: Class 2 (infinity) produces the sign, exponent field 0xFF and a zero fraction, with no flags set.
- R3: Class 3 (NaN) produces exponent field 0xFF and takes the fraction from mantissa bits 30:8. Fraction bit 22 (the quiet bit) is always forced to one. No flags are set.
- R4: Class 1 (number) with a biased exponent (exponent + 127) above zero produces that biased exponent and the rounded 23-bit fraction. Inexact is raised exactly when the guard bit, round bit or sticky bit is nonzero. The guard bit is mantissa bit 7, the round bit is bit 6, and sticky is bits 5:0 ORed with `sticky_i`.
- R5: Rounding mode 0 (nearest-even) rounds up when guard is set and any of round, sticky or the kept LSB is set. An exact tie therefore goes to the even neighbour.
- R6: Mode 1 truncates toward zero. Mode 2 rounds the magnitude up on any inexact positive value. Mode 3 rounds the magnitude up on any inexact negative value.
- R7: If rounding a normal carries the mantissa to 2.0, the exponent field goes up by one and the fraction is zero.
- R8: A biased exponent of 255 or more after rounding raises overflow and inexact. The word is infinity in mode 0, in mode 2 for positive values and in mode 3 for negative values. Otherwise it is the largest finite magnitude, 0x7F7FFFFF with the sign applied.
- R9: A biased exponent at or below zero gives a subnormal. The exponent field is 0, and the fraction is the mantissa shifted right by a further (1 - biased exponent) places and then rounded. Shifts of 32 or more send the whole mantissa into sticky.
- R10: A subnormal that rounds up into the implied-one position produces the smallest normal: exponent field 1 and fraction 0. Inexact is raised and underflow is not.
- R11: A result that stays subnormal raises underflow when it is inexact or when `uf_trap_en_i` is high.
- R12: `valid_o` is high in the cycle after each cycle with `valid_i` high and low otherwise. Reset clears `valid_o`, the word and the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input value present |
| class_i | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| sign_i | input | 1 | Sign of the value |
| exp_i | input | EXP_W (10) | Signed unbiased exponent |
| mant_i | input | MANT_W (32) | Mantissa, leading one at the top bit |
| sticky_i | input | 1 | Nonzero bits already discarded upstream |
| rmode_i | input | 2 | 0 nearest-even, 1 to zero, 2 to +inf, 3 to -inf |
| uf_trap_en_i | input | 1 | Underflow trap enabled |
| valid_o | output | 1 | Packed result present |
| word_o | output | 32 | Packed single-precision word |
| of_o | output | 1 | Overflow flag |
| uf_o | output | 1 | Underflow flag |
| nx_o | output | 1 | Inexact flag |

## Verification
Rounding and range handling can land in the same cycle, because a round-up carry can move a result across a format boundary. The bench provokes this in two ways. It feeds a largest-exponent mantissa of all ones, whose carry must end in overflow. It also feeds a subnormal of all ones just below the normal range, whose carry must give the smallest normal with underflow suppressed. Both words and all three flags are compared against hand-derived values from a scoreboard queue. Directed overflow cases in each rounding mode and exact and inexact subnormals, with the trap both on and off, separate the carry effect from plain overflow and plain underflow.

// File: rtl/sp_pack_pkg.sv
package sp_pack_pkg;
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NUM  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } val_class_e;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_TO_ZERO   = 2'd1,
    RM_TO_POS    = 2'd2,
    RM_TO_NEG    = 2'd3
  } rnd_mode_e;

  localparam int unsigned FRAC_W = 23;
  localparam int unsigned EXPF_W = 8;
  localparam int unsigned BIAS   = 127;
endpackage

// File: rtl/sp_align.sv
module sp_align #(
  parameter int unsigned MANT_W = 32,
  parameter int unsigned EXP_W  = 10,
  parameter int unsigned FRAC_W = 23,
  parameter int unsigned BIAS   = 127,
  localparam int unsigned KEEP_W = FRAC_W + 3,
  localparam int unsigned BW     = EXP_W + 2
) (
  input  logic signed [EXP_W-1:0]  exp_i,
  input  logic        [MANT_W-1:0] mant_i,
  input  logic                     sticky_i,
  output logic signed [BW-1:0]     biased_o,
  output logic                     tiny_o,
  output logic        [KEEP_W-1:0] keep_o,
  output logic                     sticky_o
);
  localparam int unsigned BASE_SH = MANT_W - KEEP_W;

  logic [BW-1:0]     shamt;
  logic [MANT_W-1:0] lost_mask;

  always_comb begin
    biased_o = {{2{exp_i[EXP_W-1]}}, exp_i} + BW'(BIAS);
    tiny_o   = (biased_o <= 0);
    // subnormal: extra right shift of (1 - biased)
    shamt    = tiny_o ? (BW'(BASE_SH + 1) - biased_o) : BW'(BASE_SH);
    if (shamt >= BW'(MANT_W)) begin
      keep_o    = '0;
      lost_mask = '1;
    end else begin
      keep_o    = KEEP_W'(mant_i >> shamt);
      lost_mask = ~({MANT_W{1'b1}} << shamt);
    end
    sticky_o = sticky_i | (|(mant_i & lost_mask));
  end
endmodule

// File: rtl/sp_round.sv
module sp_round
  import sp_pack_pkg::*;
#(
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned KEEP_W = FRAC_W + 3,
  localparam int unsigned SIG_W  = FRAC_W + 2
) (
  input  logic [KEEP_W-1:0] keep_i,
  input  logic              sticky_i,
  input  logic              sign_i,
  input  logic [1:0]        mode_i,
  output logic [SIG_W-1:0]  sig_o,
  output logic              inexact_o
);
  logic [FRAC_W:0] m;
  logic            g, r, up;

  always_comb begin
    m         = keep_i[KEEP_W-1:2];
    g         = keep_i[1];
    r         = keep_i[0];
    inexact_o = g | r | sticky_i;
    unique case (mode_i)
      RM_NEAR_EVEN: up = g & (r | sticky_i | m[0]);
      RM_TO_ZERO:   up = 1'b0;
      RM_TO_POS:    up = inexact_o & ~sign_i;
      default:      up = inexact_o & sign_i;
    endcase
    sig_o = {1'b0, m} + SIG_W'(up);
  end
endmodule

// File: rtl/sp_assemble.sv
module sp_assemble
  import sp_pack_pkg::*;
#(
  parameter int unsigned FRAC_W = 23,
  parameter int unsigned EXPF_W = 8,
  parameter int unsigned BW     = 12,
  localparam int unsigned WORD_W  = 1 + EXPF_W + FRAC_W,
  localparam int unsigned SIG_W   = FRAC_W + 2,
  localparam int unsigned EXP_MAX = (1 << EXPF_W) - 1
) (
  input  logic [1:0]           class_i,
  input  logic                 sign_i,
  input  logic [FRAC_W-1:0]    nan_frac_i,
  input  logic [1:0]           mode_i,
  input  logic                 uf_trap_en_i,
  input  logic signed [BW-1:0] biased_i,
  input  logic                 tiny_i,
  input  logic [SIG_W-1:0]     sig_i,
  input  logic                 inexact_i,
  output logic [WORD_W-1:0]    word_o,
  output logic                 of_o,
  output logic                 uf_o,
  output logic                 nx_o
);
  localparam logic signed [BW-1:0] EMAX_S = BW'(EXP_MAX);
  localparam logic [EXPF_W-1:0]    E_ONES = '1;
  localparam logic [FRAC_W-1:0]    QUIET  = FRAC_W'(1) << (FRAC_W - 1);

  logic signed [BW-1:0] e_fin;
  logic                 to_inf;

  always_comb begin
    e_fin = biased_i + BW'(sig_i[SIG_W-1]);
    unique case (mode_i)
      RM_NEAR_EVEN: to_inf = 1'b1;
      RM_TO_ZERO:   to_inf = 1'b0;
      RM_TO_POS:    to_inf = ~sign_i;
      default:      to_inf = sign_i;
    endcase

    word_o = {sign_i, {(WORD_W-1){1'b0}}};
    of_o   = 1'b0;
    uf_o   = 1'b0;
    nx_o   = 1'b0;
    unique case (class_i)
      CLS_ZERO: ;
      CLS_INF:  word_o = {sign_i, E_ONES, {FRAC_W{1'b0}}};
      CLS_NAN:  word_o = {sign_i, E_ONES, nan_frac_i | QUIET};
      default: begin
        nx_o = inexact_i;
        if (tiny_i) begin
          if (sig_i[FRAC_W]) begin
            // rounded into the smallest normal
            word_o = {sign_i, EXPF_W'(1), {FRAC_W{1'b0}}};
          end else begin
            word_o = {sign_i, {EXPF_W{1'b0}}, sig_i[FRAC_W-1:0]};
            uf_o   = inexact_i | uf_trap_en_i;
          end
        end else if (e_fin >= EMAX_S) begin
          of_o   = 1'b1;
          nx_o   = 1'b1;
          word_o = to_inf ? {sign_i, E_ONES, {FRAC_W{1'b0}}}
                          : {sign_i, E_ONES - EXPF_W'(1), {FRAC_W{1'b1}}};
        end else begin
          // carry to 2.0 leaves the fraction field zero
          word_o = {sign_i, e_fin[EXPF_W-1:0], sig_i[FRAC_W-1:0]};
        end
      end
    endcase
  end
endmodule

// File: rtl/sp_packer.sv
module sp_packer
  import sp_pack_pkg::*;
#(
  parameter int unsigned MANT_W = 32,
  parameter int unsigned EXP_W  = 10,
  localparam int unsigned WORD_W = 1 + EXPF_W + FRAC_W,
  localparam int unsigned KEEP_W = FRAC_W + 3,
  localparam int unsigned SIG_W  = FRAC_W + 2,
  localparam int unsigned BW     = EXP_W + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [1:0]               class_i,
  input  logic                     sign_i,
  input  logic signed [EXP_W-1:0]  exp_i,
  input  logic [MANT_W-1:0]        mant_i,
  input  logic                     sticky_i,
  input  logic [1:0]               rmode_i,
  input  logic                     uf_trap_en_i,
  output logic                     valid_o,
  output logic [WORD_W-1:0]        word_o,
  output logic                     of_o,
  output logic                     uf_o,
  output logic                     nx_o
);
  logic signed [BW-1:0] biased;
  logic                 tiny, sticky_a, inexact;
  logic [KEEP_W-1:0]    keep;
  logic [SIG_W-1:0]     sig;
  logic [WORD_W-1:0]    word_d;
  logic                 of_d, uf_d, nx_d;

  sp_align #(.MANT_W(MANT_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W), .BIAS(BIAS)) u_align (
    .exp_i   (exp_i),
    .mant_i  (mant_i),
    .sticky_i(sticky_i),
    .biased_o(biased),
    .tiny_o  (tiny),
    .keep_o  (keep),
    .sticky_o(sticky_a)
  );

  sp_round #(.FRAC_W(FRAC_W)) u_round (
    .keep_i   (keep),
    .sticky_i (sticky_a),
    .sign_i   (sign_i),
    .mode_i   (rmode_i),
    .sig_o    (sig),
    .inexact_o(inexact)
  );

  sp_assemble #(.FRAC_W(FRAC_W), .EXPF_W(EXPF_W), .BW(BW)) u_assemble (
    .class_i     (class_i),
    .sign_i      (sign_i),
    .nan_frac_i  (mant_i[MANT_W-2 -: FRAC_W]),
    .mode_i      (rmode_i),
    .uf_trap_en_i(uf_trap_en_i),
    .biased_i    (biased),
    .tiny_i      (tiny),
    .sig_i       (sig),
    .inexact_i   (inexact),
    .word_o      (word_d),
    .of_o        (of_d),
    .uf_o        (uf_d),
    .nx_o        (nx_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      word_o  <= '0;
      of_o    <= 1'b0;
      uf_o    <= 1'b0;
      nx_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        word_o <= word_d;
        of_o   <= of_d;
        uf_o   <= uf_d;
        nx_o   <= nx_d;
      end
    end
  end

  p_valid_follow_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_of_sets_nx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && of_o) |-> nx_o);
  p_of_magnitude_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && of_o) |->
      (word_o[WORD_W-2:0] == {{EXPF_W{1'b1}}, {FRAC_W{1'b0}}} ||
       word_o[WORD_W-2:0] == {{(EXPF_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}}));
  p_uf_exp_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && uf_o) |-> (word_o[WORD_W-2 -: EXPF_W] == '0 && !of_o));
  p_nan_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && word_o[WORD_W-2 -: EXPF_W] == '1 && |word_o[FRAC_W-1:0])
      |-> word_o[FRAC_W-1]);
endmodule

// File: tb/sp_packer_tb.sv
module sp_packer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  class_i = '0;
  logic        sign_i = 1'b0;
  logic signed [9:0] exp_i = '0;
  logic [31:0] mant_i = '0;
  logic        sticky_i = 1'b0;
  logic [1:0]  rmode_i = '0;
  logic        uf_trap_en_i = 1'b0;
  logic        valid_o;
  logic [31:0] word_o;
  logic        of_o, uf_o, nx_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sp_packer u_dut (
    .clk_i, .rst_ni, .valid_i, .class_i, .sign_i, .exp_i, .mant_i,
    .sticky_i, .rmode_i, .uf_trap_en_i, .valid_o, .word_o, .of_o, .uf_o, .nx_o
  );

  typedef struct {
    logic [31:0] word;
    logic        of_f, uf_f, nx_f;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_run = 0;
  int   n_fail = 0;
  int   n_sent = 0;
  int   n_seen = 0;

  // class: 0 zero,1 num,2 inf,3 nan; mode: 0 RNE,1 RZ,2 +inf,3 -inf
  task automatic send(input logic [1:0] cls, input logic sg, input int e,
                      input logic [31:0] m, input logic st, input logic [1:0] md,
                      input logic trap, input logic [31:0] w, input logic of_e,
                      input logic uf_e, input logic nx_e, input string tag);
    exp_t it;
    @(negedge clk_i);
    valid_i = 1'b1; class_i = cls; sign_i = sg; exp_i = 10'(e);
    mant_i = m; sticky_i = st; rmode_i = md; uf_trap_en_i = trap;
    it.word = w; it.of_f = of_e; it.uf_f = uf_e; it.nx_f = nx_e; it.tag = tag;
    sb_q.push_back(it);
    n_sent++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      n_seen++;
      n_run++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL R12 unexpected valid_o, actual word %08h expected none", word_o);
      end else begin
        exp_t it;
        it = sb_q.pop_front();
        if (word_o !== it.word || of_o !== it.of_f || uf_o !== it.uf_f || nx_o !== it.nx_f) begin
          n_fail++;
          $display("FAIL %s actual %08h of%0b uf%0b nx%0b expected %08h of%0b uf%0b nx%0b",
                   it.tag, word_o, of_o, uf_o, nx_o, it.word, it.of_f, it.uf_f, it.nx_f);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired, actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_run++;
    if (valid_o !== 1'b0 || word_o !== 32'h0 || of_o || uf_o || nx_o) begin
      n_fail++;
      $display("FAIL R12 reset state actual v%0b %08h expected v0 00000000", valid_o, word_o);
    end
    rst_ni = 1'b1;

    send(0, 1, 0, 32'h0, 0, 0, 0, 32'h8000_0000, 0, 0, 0, "R1 neg zero");
    send(2, 0, 0, 32'h0, 0, 0, 0, 32'h7F80_0000, 0, 0, 0, "R2 pos inf");
    send(2, 1, 0, 32'h0, 0, 1, 0, 32'hFF80_0000, 0, 0, 0, "R2 neg inf");
    send(3, 0, 0, 32'h8000_0100, 0, 0, 0, 32'h7FC0_0001, 0, 0, 0, "R3 nan payload");
    send(3, 1, 0, 32'h8AAA_AA00, 0, 0, 0, 32'hFFCA_AAAA, 0, 0, 0, "R3 nan quiet forced");
    send(1, 0, 0, 32'h8000_0000, 0, 0, 0, 32'h3F80_0000, 0, 0, 0, "R4 one");
    send(1, 0, 1, 32'hC000_0000, 0, 0, 0, 32'h4040_0000, 0, 0, 0, "R4 three");
    send(1, 0, 0, 32'h8000_0000, 1, 0, 0, 32'h3F80_0000, 0, 0, 1, "R4 sticky_i only");
    idle(2);
    send(1, 0, 0, 32'h8000_0080, 0, 0, 0, 32'h3F80_0000, 0, 0, 1, "R5 tie even stays");
    send(1, 0, 0, 32'h8000_0180, 0, 0, 0, 32'h3F80_0002, 0, 0, 1, "R5 tie odd up");
    send(1, 0, 0, 32'h8000_01FF, 0, 1, 0, 32'h3F80_0001, 0, 0, 1, "R6 to zero");
    send(1, 0, 0, 32'h8000_01FF, 0, 2, 0, 32'h3F80_0002, 0, 0, 1, "R6 to pos");
    send(1, 1, 0, 32'h8000_0001, 0, 3, 0, 32'hBF80_0001, 0, 0, 1, "R6 to neg negative");
    send(1, 0, 0, 32'h8000_00FF, 0, 3, 0, 32'h3F80_0000, 0, 0, 1, "R6 to neg positive");
    send(1, 0, 0, 32'hFFFF_FF80, 0, 0, 0, 32'h4000_0000, 0, 0, 1, "R7 carry to 2.0");
    send(1, 0, 128, 32'h8000_0000, 0, 0, 0, 32'h7F80_0000, 1, 0, 1, "R8 of nearest");
    send(1, 0, 128, 32'h8000_0000, 0, 1, 0, 32'h7F7F_FFFF, 1, 0, 1, "R8 of to zero");
    send(1, 1, 128, 32'h8000_0000, 0, 2, 0, 32'hFF7F_FFFF, 1, 0, 1, "R8 of neg to pos");
    send(1, 1, 128, 32'h8000_0000, 0, 3, 0, 32'hFF80_0000, 1, 0, 1, "R8 of neg to neg");
    send(1, 0, 127, 32'hFFFF_FFFF, 0, 0, 0, 32'h7F80_0000, 1, 0, 1, "R8 R7 carry overflow");
    send(1, 0, -127, 32'h8000_0000, 0, 0, 0, 32'h0040_0000, 0, 0, 0, "R9 exact subnormal");
    send(1, 0, -127, 32'h8000_0000, 0, 0, 1, 32'h0040_0000, 0, 1, 0, "R11 trap exact subnormal");
    send(1, 0, -130, 32'h8000_0001, 0, 0, 0, 32'h0008_0000, 0, 1, 1, "R11 R9 inexact subnormal");
    send(1, 1, -127, 32'hFFFF_FFFF, 0, 0, 0, 32'h8080_0000, 0, 0, 1, "R10 round into normal");
    send(1, 0, -200, 32'h8000_0000, 0, 0, 0, 32'h0000_0000, 0, 1, 1, "R9 deep flush");
    send(1, 0, -200, 32'h8000_0000, 0, 2, 0, 32'h0000_0001, 0, 1, 1, "R9 deep to pos");
    idle(4);

    n_run++;
    if (n_seen != n_sent || sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R12 result count actual %0d expected %0d", n_seen, n_sent);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule